// File: doc/BRIEF.md
# Bitwise Logic Unit with Sign-Extended Immediate

This block is the logical-operation slice of an integer execution pipeline. It combines a 64-bit left operand and a 64-bit right operand bit by bit under a 2-bit operation code. The four operations are AND, OR, XOR and AND-with-inverted-right. A select flag lets an 8-bit immediate stand in for the left operand. The immediate is always sign-extended to the full width before it is used. The right operand always comes from the register path.

The combining logic is purely combinational and is split into byte lanes. A single output stage captures the lane results on the clock edge where `in_valid` is high. The next cycle then shows the result together with a one-cycle `out_valid` pulse. Typical uses are setting, clearing, toggling and testing bit fields against a mask, including forcing the case of ASCII letters with a short immediate.

Top module: `bitlogic_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) drives `out_valid` to 0, even while `in_valid` is high.
- R2: `out_valid` is 1 in the cycle after each edge that samples `in_valid` high, and 0 otherwise. A sampled `in_valid` of 0 leaves `result` unchanged.
- R3: `op` = 2'b00 gives `result` = left AND right.
- R4: `op` = 2'b01 gives `result` = left AND (NOT right). Only the right operand is inverted.
- R5: `op` = 2'b10 gives `result` = left OR right.
- R6: `op` = 2'b11 gives `result` = left XOR right.
- R7: With `use_imm` = 1 the left operand is the 8-bit `imm` sign-extended to 64 bits. When `imm[7]` is 1, bits 63:8 of the left operand are all ones. Example: `imm` 0xA5 with a right operand whose top byte is 0x26 and low byte is 0x19 gives these (top, low) byte pairs: AND 0x26/0x01, OR 0xFF/0xBD, AND-inverted 0xD9/0xA4, XOR 0xD9/0xBC.
- R8: With `use_imm` = 1 and `imm[7]` = 0, bits 63:8 of the left operand are zero.
- R9: `left_reg` has no effect when `use_imm` = 1. The right operand is always `right_reg`.
- R10: AND, OR and XOR give the same result when the two register operands are swapped. AND-inverted gives a different result for unequal operands.
- R11: OR with immediate 0x20 turns an ASCII capital into its lowercase code. AND with immediate 0xDF (the complement of 0x20) turns a lowercase letter into its capital code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op | input | 2 | 00 AND, 01 AND-inverted-right, 10 OR, 11 XOR |
| use_imm | input | 1 | 1: left operand is the sign-extended `imm` |
| left_reg | input | 64 | Left register operand |
| imm | input | 8 | Immediate for the left side |
| right_reg | input | 64 | Right register operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Registered logic result |

## Verification
Two events share a clock edge under back-to-back issue. The output stage presents one operation's result while it captures the next operation. The bench provokes this by driving `in_valid` on consecutive cycles with different operations and immediate/register selections. A queue of expected values then has to match the results in order, with `out_valid` high on every one of those cycles. The same edge also combines sign extension with AND-inverted, and the 0xA5 example is judged byte by byte through the scoreboard.

// File: rtl/blu_pkg.sv
// Package: shared definitions of the bitwise logic unit.
// Assumes: the operation code is 2 bits wide and its encoding is fixed.
package blu_pkg;
    typedef enum logic [1:0] {
        BLU_AND  = 2'b00,
        BLU_ANDN = 2'b01,
        BLU_OR   = 2'b10,
        BLU_XOR  = 2'b11
    } blu_op_e;
endpackage

// File: rtl/blu_operand_sel.sv
// Module: picks the left operand, either a register value or the
// sign-extended immediate.
// Assumes: IMM_W < DATA_W. The immediate is always treated as signed.
module blu_operand_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] left_reg,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] left_op
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Replicate the immediate's sign bit across the upper bits.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Pass the register value or the extended immediate.
    always_comb begin
        left_op = use_imm ? imm_ext : left_reg;
    end
endmodule

// File: rtl/blu_lane.sv
// Module: one lane of the bitwise combiner.
// Assumes: op is one of the blu_op_e codes. All bits are independent.
module blu_lane
    import blu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  blu_op_e           op,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    // Pick the per-bit boolean function for this lane.
    always_comb begin
        unique case (op)
            BLU_AND:  y = a & b;
            BLU_ANDN: y = a & ~b;
            BLU_OR:   y = a | b;
            BLU_XOR:  y = a ^ b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/blu_out_stage.sv
// Module: output register with a one-cycle valid pulse.
// Assumes: synchronous active-low reset. The data path is not reset.
module blu_out_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] d,
    output logic              vld,
    output logic [DATA_W-1:0] q
);
    // The valid pulse follows the capture strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= cap;
    end

    // Load new data only on capture, otherwise hold it.
    always_ff @(posedge clk) begin
        if (cap) q <= d;
    end
endmodule

// File: rtl/bitlogic_unit.sv
// Module: top of the bitwise logic unit. Operand select, lane combiner
// and a single output register.
// Assumes: DATA_W is a multiple of LANE_W. Latency is one cycle.
module bitlogic_unit
    import blu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] left_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] right_reg,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    blu_op_e           op_e;
    logic [DATA_W-1:0] left_op;
    logic [DATA_W-1:0] comb_res;

    // Interpret the raw op code as the operation type.
    always_comb begin
        op_e = blu_op_e'(op);
    end

    blu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .use_imm  (use_imm),
        .left_reg (left_reg),
        .imm      (imm),
        .left_op  (left_op)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        blu_lane #(.LANE_W(LANE_W)) u_lane (
            .op (op_e),
            .a  (left_op[g*LANE_W +: LANE_W]),
            .b  (right_reg[g*LANE_W +: LANE_W]),
            .y  (comb_res[g*LANE_W +: LANE_W])
        );
    end

    blu_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (in_valid),
        .d     (comb_res),
        .vld   (out_valid),
        .q     (result)
    );
endmodule

// File: rtl/bitlogic_unit_chk.sv
// Module: property checker for bitlogic_unit, attached with bind.
// Assumes: the default 64-bit width and 8-bit immediate.
module bitlogic_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  op,
    input logic        use_imm,
    input logic [63:0] right_reg,
    input logic [63:0] left_reg,
    input logic [7:0]  imm,
    input logic        out_valid,
    input logic [63:0] result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R3
    and_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && op == 2'b00)
        |=> result == ($past(left_reg) & $past(right_reg)));

    // R4
    andn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01) |=> (result & $past(right_reg)) == 64'd0);

    // R7
    sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_imm && imm[7] && op == 2'b10)
        |=> result[63:8] == {56{1'b1}});

    // R8
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_imm && !imm[7] && op == 2'b00)
        |=> result[63:8] == 56'd0);
endmodule

bind bitlogic_unit bitlogic_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .use_imm   (use_imm),
    .right_reg (right_reg),
    .left_reg  (left_reg),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_bitlogic_unit.sv
// Bench: scoreboard for bitlogic_unit. A driver task queues the expected
// results, and a monitor checks them one cycle after capture.
module sim_bitlogic_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        use_imm = 1'b0;
    logic [63:0] left_reg = '0;
    logic [7:0]  imm = '0;
    logic [63:0] right_reg = '0;
    logic        out_valid;
    logic [63:0] result;

    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];
    logic [63:0] last_res = '0;
    bit   have_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitlogic_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .use_imm(use_imm), .left_reg(left_reg), .imm(imm),
        .right_reg(right_reg), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] o, input bit s,
            input logic [63:0] l, input logic [7:0] i, input logic [63:0] r);
        logic [63:0] a;
        a = s ? {{56{i[7]}}, i} : l;
        case (o)
            2'b00:   return a & r;
            2'b01:   return a & ~r;
            2'b10:   return a | r;
            default: return a ^ r;
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation for a single cycle and queue its expected value.
    task automatic issue(input logic [1:0] o, input bit s, input logic [63:0] l,
                         input logic [7:0] i, input logic [63:0] r, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; use_imm = s; left_reg = l; imm = i; right_reg = r;
        e.val = model(o, s, l, i, r);
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            left_reg = ~left_reg;
            right_reg = right_reg + 64'd3;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: after each edge, match out_valid against the queue and
    // compare the result.
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(out_valid === 1'b1, {e.req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
                check(result === e.val, e.req, result, e.val);
                last_res = result;
                have_last = 1'b1;
            end else begin
                check(out_valid === 1'b0, "R2 idle valid", {63'd0, out_valid}, 64'd0);
                if (have_last)
                    check(result === last_res, "R2 hold", result, last_res);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        // R1: reset with in_valid held high
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset", {63'd0, out_valid}, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 after reset", {63'd0, out_valid}, 64'd0);
        mon_on = 1'b1;

        // R3..R6 on register operands
        issue(2'b00, 0, 64'hF0F0_1234_AAAA_5555, 8'h00, 64'hFF00_FFFF_0F0F_00FF, "R3 and");
        issue(2'b01, 0, 64'hF0F0_1234_AAAA_5555, 8'h00, 64'hFF00_FFFF_0F0F_00FF, "R4 andn");
        issue(2'b10, 0, 64'h8000_0000_0000_0001, 8'h00, 64'h0000_0001_8000_0000, "R5 or");
        issue(2'b11, 0, 64'hDEAD_BEEF_0123_4567, 8'h00, 64'hFFFF_0000_FFFF_0000, "R6 xor");
        idle(2);

        // R7: 0xA5 example, sign-extended immediate
        issue(2'b00, 1, 64'h0, 8'hA5, 64'h2600_0000_0000_0019, "R7 and A5");
        issue(2'b10, 1, 64'h0, 8'hA5, 64'h2600_0000_0000_0019, "R7 or A5");
        issue(2'b01, 1, 64'h0, 8'hA5, 64'h2600_0000_0000_0019, "R7 andn A5");
        issue(2'b11, 1, 64'h0, 8'hA5, 64'h2600_0000_0000_0019, "R7 xor A5");
        idle(1);

        // R8: positive immediate gives zero fill; R9: left_reg ignored
        issue(2'b10, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h5A, 64'h0, "R8 R9 zero fill");
        issue(2'b11, 1, 64'h1234_5678_9ABC_DEF0, 8'h7F, 64'h0000_0000_0000_00FF, "R9 imm xor");
        idle(3);

        // R10: swap the operands
        issue(2'b00, 0, 64'h0123_4567_89AB_CDEF, 8'h0, 64'hFEDC_BA98_7654_3210, "R10 and ab");
        issue(2'b00, 0, 64'hFEDC_BA98_7654_3210, 8'h0, 64'h0123_4567_89AB_CDEF, "R10 and ba");
        issue(2'b10, 0, 64'h0F0F_0000_1111_2222, 8'h0, 64'h00FF_3333_0000_4444, "R10 or ab");
        issue(2'b10, 0, 64'h00FF_3333_0000_4444, 8'h0, 64'h0F0F_0000_1111_2222, "R10 or ba");
        issue(2'b11, 0, 64'hAAAA_0000_FFFF_1234, 8'h0, 64'h5555_FFFF_0000_4321, "R10 xor ab");
        issue(2'b11, 0, 64'h5555_FFFF_0000_4321, 8'h0, 64'hAAAA_0000_FFFF_1234, "R10 xor ba");
        issue(2'b01, 0, 64'hFFFF_0000_0000_0000, 8'h0, 64'h00FF_0000_0000_0000, "R10 andn ab");
        issue(2'b01, 0, 64'h00FF_0000_0000_0000, 8'h0, 64'hFFFF_0000_0000_0000, "R10 andn ba");
        idle(1);

        // R11: ASCII case conversion
        issue(2'b10, 1, 64'h0, 8'h20, 64'h41, "R11 lower");
        issue(2'b00, 1, 64'h0, 8'hDF, 64'h7A, "R11 upper");
        idle(3);

        // R10: direct check that AND-inverted is not symmetric
        check(model(2'b01, 0, 64'hF0, 8'h0, 64'h0F) !== model(2'b01, 0, 64'h0F, 8'h0, 64'hF0),
              "R10 andn asym", 64'hF0, 64'h0F);
        check(sb.size() == 0, "R2 queue drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        summary();
    end
endmodule